// File: doc/BRIEF.md
# Framed Link Test Traffic Generator

This block sources 32-bit test traffic for the transmit side of a point-to-point data link. It emits one word per clock into the link source, and each word carries a flag that marks it as a control word or a data word. Every frame opens and closes with a control word. The body between those two words follows one of three patterns, chosen by a mode input. The structured pattern imitates detector readout: a header that carries the frame number, a counting payload, and a footer derived from the frame length. The walking-bit pattern exercises every data line. The pseudo-random pattern comes from a 32-bit LFSR whose sequence can be reproduced.

While enabled, the generator sends frames back to back. A running frame counter numbers them. Mode and frame length are sampled once per frame, at the moment the opening control word is produced. Mid-frame changes therefore take effect only on the next frame. The link's ready input can stall the output at any word. The stalled word stays on the outputs until the link takes it, so no word is dropped or sent twice.

Top module: `frame_pattern_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and `frame_count` is 0. Reset also reloads the LFSR seed.
- R2: A word is transferred on every clock where `out_valid` and `link_ready` are both 1. When `out_valid` is 1 and `link_ready` is 0, the next cycle shows `out_valid` still 1 with `out_ctrl` and `out_data` unchanged. No word is lost or repeated.
- R3: A frame of length L consists of exactly L transferred words. The first is a control word (`out_ctrl`=1, value 32'h1B0FF00D) and the last is a control word (`out_ctrl`=1, value 32'hE0F0E0F0). All words between them have `out_ctrl`=0.
- R4: In structured mode, the opening word is followed by 9 header words. For header position p (0-based), the word is N at p=3, ((3N-2) mod 4096) zero-extended at p=4, and 32'hA5A50000+p at every other p. N is the frame number.
- R5: In structured mode, the header is followed by the payload 0,1,...,L-15 (L-14 words). The payload is followed by the footer words 1, L-14 and 0, in that order.
- R6: In walking-bit mode, the L-2 body words are 1<<(i mod 32) for body index i = 0,1,...
- R7: In pseudo-random mode, each of the L-2 body words is the current LFSR state s, after which the state becomes (s>>1) XOR (s[0] ? 32'h80200003 : 0). The seed is 32'h2545F491. The state advances only on pseudo-random body words and carries on from one frame to the next.
- R8: `mode_sel` encoding: 0 and 3 select structured, 1 selects walking-bit, 2 selects pseudo-random. Mode and length are sampled when a frame's opening word is produced, so changes made during a frame apply to the next frame.
- R9: Length values below 16 are treated as 16, and values above 1024 as 1024.
- R10: `frame_count` increases by exactly 1 when a frame's opening word is produced and changes at no other time. The first frame after reset is number 1, and the count wraps modulo 2^32.
- R11: A new frame starts only while `enable` is 1. A frame already under way always completes. With `enable` and `link_ready` both held at 1, frames follow one another with `out_valid` never dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Permits new frames to start |
| mode_sel | input | 2 | Pattern select, sampled at frame start |
| frame_len | input | 11 | Frame length in words, sampled at frame start and clamped to 16..1024 |
| link_ready | input | 1 | Link can take the presented word this cycle |
| out_valid | output | 1 | A word is presented |
| out_ctrl | output | 1 | Presented word is a control word |
| out_data | output | 32 | Presented word |
| frame_count | output | 32 | Number of the most recently started frame |

## Verification
The frame boundary is where two functions meet in one cycle. The link can accept the closing control word on the same edge at which the next opening word is loaded. On that edge the new mode and length are latched and the frame counter steps. The bench provokes this coincidence in two ways. It keeps `link_ready` high through long runs, and it also drives it with a random stall pattern, so the closing word can either pass straight through or wait on the outputs while the configuration inputs are changing mid-frame. A behavioural model builds each expected frame from the configuration held at that boundary and compares every transferred word. It also checks that a stalled word reappears unchanged and that `out_valid` never gaps during unstalled runs.

// File: rtl/tfg_pkg.sv
package tfg_pkg;

  typedef enum logic [1:0] {
    MODE_STRUCT     = 2'd0,
    MODE_WALK       = 2'd1,
    MODE_PRBS       = 2'd2,
    MODE_STRUCT_ALT = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    PH_SOF  = 3'd0,
    PH_HDR  = 3'd1,
    PH_BODY = 3'd2,
    PH_FTR  = 3'd3,
    PH_EOF  = 3'd4
  } phase_e;

  localparam int HDR_WORDS    = 9;
  localparam int FTR_WORDS    = 3;
  localparam int HDR_NUM_POS  = 3;
  localparam int HDR_TAG_POS  = 4;
  localparam int CTRL_WORDS   = 2;
  // words of a structured frame that are not payload
  localparam int STRUCT_FIXED = CTRL_WORDS + HDR_WORDS + FTR_WORDS;

  function automatic logic is_struct(mode_e m);
    return (m != MODE_WALK) && (m != MODE_PRBS);
  endfunction

endpackage

// File: rtl/tfg_lfsr.sv
module tfg_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] SEED = 32'h2545F491,
  parameter logic [W-1:0] POLY = 32'h80200003
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] state
);

  logic [W-1:0] nxt;

  // Galois form, shifting toward bit 0
  always_comb begin
    nxt = {1'b0, state[W-1:1]};
    if (state[0]) nxt = nxt ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= nxt;
  end

endmodule

// File: rtl/tfg_seq.sv
module tfg_seq
  import tfg_pkg::*;
#(
  parameter int MIN_LEN = 16,
  parameter int MAX_LEN = 1024,
  parameter int LW      = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [1:0]    mode_in,
  input  logic [LW-1:0] len_in,
  output phase_e        phase,
  output logic [LW-1:0] idx,
  output mode_e         mode_q,
  output logic [LW-1:0] len_q,
  output logic [31:0]   frame_n
);

  logic [LW-1:0] len_c;
  logic [LW-1:0] body_last;
  mode_e         mode_new;

  assign mode_new = mode_e'(mode_in);

  always_comb begin
    if (len_in < LW'(MIN_LEN))      len_c = LW'(MIN_LEN);
    else if (len_in > LW'(MAX_LEN)) len_c = LW'(MAX_LEN);
    else                            len_c = len_in;
  end

  // index of the final body word for the latched frame
  always_comb begin
    if (is_struct(mode_q)) body_last = len_q - LW'(STRUCT_FIXED + 1);
    else                   body_last = len_q - LW'(CTRL_WORDS + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_SOF;
      idx     <= '0;
      mode_q  <= MODE_STRUCT;
      len_q   <= LW'(MIN_LEN);
      frame_n <= '0;
    end else if (step) begin
      case (phase)
        PH_SOF: begin
          mode_q  <= mode_new;
          len_q   <= len_c;
          frame_n <= frame_n + 32'd1;
          idx     <= '0;
          phase   <= is_struct(mode_new) ? PH_HDR : PH_BODY;
        end
        PH_HDR: begin
          if (idx == LW'(HDR_WORDS - 1)) begin
            idx   <= '0;
            phase <= PH_BODY;
          end else begin
            idx <= idx + LW'(1);
          end
        end
        PH_BODY: begin
          if (idx == body_last) begin
            idx   <= '0;
            phase <= is_struct(mode_q) ? PH_FTR : PH_EOF;
          end else begin
            idx <= idx + LW'(1);
          end
        end
        PH_FTR: begin
          if (idx == LW'(FTR_WORDS - 1)) begin
            idx   <= '0;
            phase <= PH_EOF;
          end else begin
            idx <= idx + LW'(1);
          end
        end
        default: begin
          idx   <= '0;
          phase <= PH_SOF;
        end
      endcase
    end
  end

endmodule

// File: rtl/tfg_word.sv
module tfg_word
  import tfg_pkg::*;
#(
  parameter int                   LW       = 11,
  parameter logic [31:0]          SOF_WORD = 32'h1B0FF00D,
  parameter logic [31:0]          EOF_WORD = 32'hE0F0E0F0,
  parameter logic [HDR_WORDS-1:0][31:0] HDR_INIT = '0
) (
  input  phase_e        phase,
  input  logic [LW-1:0] idx,
  input  mode_e         mode_q,
  input  logic [LW-1:0] len_q,
  input  logic [31:0]   frame_n,
  input  logic [31:0]   lfsr_q,
  output logic          w_ctrl,
  output logic [31:0]   w_data
);

  logic [31:0] hdr_word;
  logic [31:0] body_word;
  logic [31:0] ftr_word;
  logic [31:0] tag_full;

  assign tag_full = (frame_n * 32'd3) - 32'd2;

  always_comb begin
    hdr_word = '0;
    for (int k = 0; k < HDR_WORDS; k++) begin
      if (idx == LW'(k)) begin
        if (k == HDR_NUM_POS)      hdr_word = frame_n;
        else if (k == HDR_TAG_POS) hdr_word = {20'd0, tag_full[11:0]};
        else                       hdr_word = HDR_INIT[k];
      end
    end
  end

  always_comb begin
    case (mode_q)
      MODE_WALK: body_word = 32'd1 << idx[4:0];
      MODE_PRBS: body_word = lfsr_q;
      default:   body_word = 32'(idx);
    endcase
  end

  always_comb begin
    case (idx[1:0])
      2'd0:    ftr_word = 32'd1;
      2'd1:    ftr_word = 32'(len_q) - 32'(STRUCT_FIXED);
      default: ftr_word = 32'd0;
    endcase
  end

  always_comb begin
    w_ctrl = 1'b0;
    case (phase)
      PH_SOF:  begin w_ctrl = 1'b1; w_data = SOF_WORD; end
      PH_HDR:  w_data = hdr_word;
      PH_BODY: w_data = body_word;
      PH_FTR:  w_data = ftr_word;
      default: begin w_ctrl = 1'b1; w_data = EOF_WORD; end
    endcase
  end

endmodule

// File: rtl/frame_pattern_gen.sv
module frame_pattern_gen
  import tfg_pkg::*;
#(
  parameter int          MIN_LEN   = 16,
  parameter int          MAX_LEN   = 1024,
  parameter logic [31:0] SOF_WORD  = 32'h1B0FF00D,
  parameter logic [31:0] EOF_WORD  = 32'hE0F0E0F0,
  parameter logic [HDR_WORDS-1:0][31:0] HDR_INIT = {
    32'hA5A50008, 32'hA5A50007, 32'hA5A50006, 32'hA5A50005, 32'hA5A50004,
    32'hA5A50003, 32'hA5A50002, 32'hA5A50001, 32'hA5A50000},
  parameter logic [31:0] PRBS_SEED = 32'h2545F491,
  parameter logic [31:0] PRBS_POLY = 32'h80200003,
  localparam int         LW        = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [1:0]    mode_sel,
  input  logic [LW-1:0] frame_len,
  input  logic          link_ready,
  output logic          out_valid,
  output logic          out_ctrl,
  output logic [31:0]   out_data,
  output logic [31:0]   frame_count
);

  phase_e        phase;
  mode_e         mode_q;
  logic [LW-1:0] idx;
  logic [LW-1:0] len_q;
  logic [31:0]   frame_n;
  logic [31:0]   lfsr_q;
  logic          w_ctrl;
  logic [31:0]   w_data;
  logic          gen_valid;
  logic          load;
  logic          step;
  logic          lfsr_adv;

  // a word is available except at a frame boundary with enable low
  assign gen_valid = (phase != PH_SOF) || enable;
  // output register may take a new word when empty or being drained
  assign load      = !out_valid || link_ready;
  assign step      = load && gen_valid;
  assign lfsr_adv  = step && (phase == PH_BODY) && (mode_q == MODE_PRBS);

  tfg_seq #(
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN),
    .LW      (LW)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .mode_in (mode_sel),
    .len_in  (frame_len),
    .phase   (phase),
    .idx     (idx),
    .mode_q  (mode_q),
    .len_q   (len_q),
    .frame_n (frame_n)
  );

  tfg_lfsr #(
    .W    (32),
    .SEED (PRBS_SEED),
    .POLY (PRBS_POLY)
  ) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .adv   (lfsr_adv),
    .state (lfsr_q)
  );

  tfg_word #(
    .LW       (LW),
    .SOF_WORD (SOF_WORD),
    .EOF_WORD (EOF_WORD),
    .HDR_INIT (HDR_INIT)
  ) u_word (
    .phase   (phase),
    .idx     (idx),
    .mode_q  (mode_q),
    .len_q   (len_q),
    .frame_n (frame_n),
    .lfsr_q  (lfsr_q),
    .w_ctrl  (w_ctrl),
    .w_data  (w_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ctrl  <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= gen_valid;
      if (gen_valid) begin
        out_ctrl <= w_ctrl;
        out_data <= w_data;
      end
    end
  end

  assign frame_count = frame_n;

endmodule

// File: rtl/tfg_checker.sv
module tfg_checker #(
  parameter logic [31:0] SOF_WORD = 32'h1B0FF00D,
  parameter logic [31:0] EOF_WORD = 32'hE0F0E0F0
) (
  input logic        clk,
  input logic        rst,
  input logic        link_ready,
  input logic        out_valid,
  input logic        out_ctrl,
  input logic [31:0] out_data,
  input logic [31:0] frame_count
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && frame_count == 32'd0));

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !link_ready) |=> (out_valid && $stable(out_ctrl) && $stable(out_data)));

  assert_ctrl_values_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ctrl) |-> (out_data == SOF_WORD || out_data == EOF_WORD));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_count == $past(frame_count)) || (frame_count == $past(frame_count) + 32'd1));

  assert_count_on_sof_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_count != $past(frame_count)) |-> (out_valid && out_ctrl && out_data == SOF_WORD));

endmodule

bind frame_pattern_gen tfg_checker #(
  .SOF_WORD (SOF_WORD),
  .EOF_WORD (EOF_WORD)
) u_tfg_checker (
  .clk         (clk),
  .rst         (rst),
  .link_ready  (link_ready),
  .out_valid   (out_valid),
  .out_ctrl    (out_ctrl),
  .out_data    (out_data),
  .frame_count (frame_count)
);

// File: tb/frame_pattern_gen_bench.sv
module frame_pattern_gen_bench;

  localparam logic [31:0] SOF_V  = 32'h1B0FF00D;
  localparam logic [31:0] EOF_V  = 32'hE0F0E0F0;
  localparam logic [31:0] SEED_V = 32'h2545F491;
  localparam logic [31:0] POLY_V = 32'h80200003;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic [10:0] frame_len = 11'd20;
  logic        link_ready = 1'b0;
  logic        out_valid;
  logic        out_ctrl;
  logic [31:0] out_data;
  logic [31:0] frame_count;

  always #2 clk = ~clk;

  frame_pattern_gen u_frame_pattern_gen (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .mode_sel    (mode_sel),
    .frame_len   (frame_len),
    .link_ready  (link_ready),
    .out_valid   (out_valid),
    .out_ctrl    (out_ctrl),
    .out_data    (out_data),
    .frame_count (frame_count)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];
  int unsigned model_n = 0;
  logic [31:0] model_lfsr = SEED_V;
  bit          hold_pending = 0;
  logic [32:0] hold_word = '0;
  bit          stream_on = 0;
  bit          finished = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void push(logic c, logic [31:0] d, string t);
    exp_q.push_back({c, d});
    tag_q.push_back(t);
  endfunction

  // builds the next expected frame from the configuration at the boundary
  function automatic void build_frame();
    int len;
    int m;
    logic [31:0] tag3;
    len = int'(frame_len);
    if (len < 16) len = 16;      // R9
    if (len > 1024) len = 1024;  // R9
    m = int'(mode_sel);
    model_n++;
    push(1'b1, SOF_V, "R3");
    if (m == 1) begin
      for (int i = 0; i < len - 2; i++) push(1'b0, 32'd1 << (i % 32), "R6");
    end else if (m == 2) begin
      for (int i = 0; i < len - 2; i++) begin
        push(1'b0, model_lfsr, "R7");
        model_lfsr = (model_lfsr >> 1) ^ (model_lfsr[0] ? POLY_V : 32'd0);
      end
    end else begin
      tag3 = (32'(model_n) * 32'd3) - 32'd2;
      for (int p = 0; p < 9; p++) begin
        if (p == 3)      push(1'b0, 32'(model_n), "R4");
        else if (p == 4) push(1'b0, {20'd0, tag3[11:0]}, "R4");
        else             push(1'b0, 32'hA5A50000 + 32'(p), "R4");
      end
      for (int v = 0; v <= len - 15; v++) push(1'b0, 32'(v), "R5");
      push(1'b0, 32'd1, "R5");
      push(1'b0, 32'(len - 14), "R5");
      push(1'b0, 32'd0, "R5");
    end
    push(1'b1, EOF_V, "R3");
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (hold_pending)
        check(out_valid && ({out_ctrl, out_data} == hold_word), "R2", "stalled word changed",
              {31'd0, out_valid, out_ctrl, out_data}, {32'd1, hold_word[32], hold_word[31:0]});
      if (stream_on)
        check(out_valid, "R11", "gap in back-to-back stream", 64'(out_valid), 64'd1);
      if (out_valid && link_ready) begin
        logic [32:0] e;
        string t;
        if (exp_q.size() == 0) begin
          build_frame();
          check(frame_count == 32'(model_n), "R10", "frame_count at frame start",
                64'(frame_count), 64'(model_n));
        end
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_ctrl, out_data} == e, t, "transferred word",
              64'({out_ctrl, out_data}), 64'(e));
      end
      hold_pending = out_valid && !link_ready;
      hold_word    = {out_ctrl, out_data};
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run(int mode, int len, int cycles, bit stall);
    mode_sel  = 2'(mode);
    frame_len = 11'(len);
    enable    = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      tick();
      link_ready = stall ? (($urandom % 4) != 0) : 1'b1;
      stream_on  = !stall && (i >= 3);
    end
    stream_on = 0;
  endtask

  // R11: lower enable, the frame under way finishes, then the output goes idle
  task automatic drain();
    enable     = 1'b0;
    link_ready = 1'b1;
    repeat (1100) tick();
    check(!out_valid, "R11", "idle after disable", 64'(out_valid), 64'd0);
    check(exp_q.size() == 0, "R11", "frame completed before idle", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    void'($urandom(7));
    repeat (4) tick();
    check(!out_valid, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
    check(frame_count == 32'd0, "R1", "frame_count in reset", 64'(frame_count), 64'd0);
    rst = 1'b0;
    check(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    tick();
    check(!out_valid, "R1", "idle while disabled", 64'(out_valid), 64'd0);

    run(0, 20, 70, 0);   drain();          // R4 R5 back to back
    run(0, 20, 200, 1);  drain();          // R2 stalls in structured mode
    run(1, 40, 130, 0);  drain();          // R6 wrap past bit 31
    run(1, 40, 200, 1);  drain();
    run(2, 50, 160, 1);  drain();          // R7 under stalls
    run(2, 18, 60, 0);   drain();          // R7 continuity across runs
    run(0, 3, 50, 0);    drain();          // R9 low clamp
    run(3, 2000, 1100, 0); drain();        // R9 high clamp, R8 mode 3
    run(0, 30, 12, 0);   run(0, 17, 80, 0); drain();  // R8 length change mid-frame
    run(1, 40, 20, 1);   run(2, 40, 100, 1); drain(); // R8 mode change mid-frame

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule